// File: doc/BRIEF.md
# Encoder Command Frame Transmitter

This block drives the transmit side of a half-duplex serial link to a position encoder. On a start pulse it captures one command frame payload, up to four memory frame payloads, a memory frame count and an inter-frame gap length. It then shifts the frames out on a serial data line together with a transmit enable and a bit clock that runs at the 1x line rate. Each 18-bit frame is a 0 start bit, 16 payload bits with the most significant bit first, and a 1 delimiter. Every frame sits in a 32-bit slot that is padded with idle ones on both sides.

The command frame always goes first. For each memory frame the line is held at idle high for a programmed number of system clock cycles, and then that memory frame's slot is sent. A one-cycle done pulse marks the end of the last slot. A start pulse that arrives during a transfer is dropped. Every input is sampled only when a transfer is accepted, so the host may change them while the block is busy. Choosing command codes, receiving the reply and the line transceiver are handled outside this block.

Top module: `enc_cmd_tx`

## Requirements
- R1: Out of reset and between transfers, ser_oe, busy, ser_clk and done are 0 and ser_data is 1.
- R2: Bits 7 to 24 of each slot form the frame: bit 7 is the 0 start bit, bits 8 to 23 carry the 16-bit payload with the most significant bit first, and bit 24 is the 1 delimiter.
- R3: Each frame takes a 32-bit slot. Slot bits 0 to 6 and 25 to 31 are idle ones, and each bit lasts CLK_DIV system clock cycles.
- R4: Before each memory frame, ser_data is held at 1 with ser_clk low and ser_oe high for exactly gap_cycles system clock cycles.
- R5: After the command frame, min(mdf_count, 4) memory frames are sent. Memory frame k (counting from 0) takes its payload from mdf_payload bits [16k+15:16k].
- R6: ser_oe and busy are 1 from the first cycle of the first slot to the last cycle of the final slot, gaps included. The total is slots*32*CLK_DIV plus (slots-1)*gap_cycles cycles.
- R7: Within each bit, ser_clk is high for the first CLK_DIV/2 cycles and low for the rest.
- R8: A start seen while the block is idle begins a transfer in the next cycle. A start seen while the block is busy is ignored, and input changes during a transfer have no effect on it.
- R9: done is 1 for exactly one cycle, the first idle cycle after the final slot.
- R10: With gap_cycles equal to 0, the next slot starts in the cycle right after the previous slot ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a transfer when idle |
| cdf_payload | input | 16 | Command frame payload |
| mdf_count | input | 3 | Number of memory frames requested |
| mdf_payload | input | 64 | Memory frame payloads, frame 0 in the low bits |
| gap_cycles | input | 16 | Idle gap before each memory frame, in system cycles |
| ser_clk | output | 1 | Bit clock at the line rate |
| ser_data | output | 1 | Serial data, idle high |
| ser_oe | output | 1 | Transmit enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Two events can fall in the same cycle. The end of a slot can coincide with the start of the next one when the gap is zero. A new start pulse can also arrive while the block is busy, and the host can alter the inputs mid-transfer. The bench provokes both cases: it runs transfers with a zero gap, and it raises start with a changed command payload in the middle of a transfer. A behavioural queue model is compared with ser_clk, ser_data, ser_oe, busy and done on every cycle. The total busy length of each transfer is also checked against the closed-form count.

// File: rtl/enc_tx_pkg.sv
// Shared types and default sizes for the encoder command frame transmitter.
package enc_tx_pkg;

    // Sequencer state: idle, shifting a slot, or holding the inter-frame gap.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SLOT = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_t;

    localparam int PAY_BITS_DEF  = 16;
    localparam int SLOT_BITS_DEF = 32;
    localparam int LEAD_BITS_DEF = 7;

endpackage

// File: rtl/enc_tx_bit_timer.sv
// Bit timer: splits a slot into SLOT_W bits of CLK_DIV cycles each.
// Assumes CLK_DIV >= 2. Clears whenever run is low, and wraps by itself at
// the end of a slot so that back-to-back slots keep their bit timing.
module enc_tx_bit_timer #(
    parameter int CLK_DIV = 4,
    parameter int SLOT_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    output logic [$clog2(SLOT_W)-1:0] bit_idx,
    output logic                      slot_last,
    output logic                      clk_phase
);
    localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int IDX_W  = $clog2(SLOT_W);
    localparam int HALF   = CLK_DIV / 2;

    logic [DIV_W-1:0] div_q;
    logic [IDX_W-1:0] idx_q;
    logic             bit_end;

    assign bit_end   = (div_q == DIV_W'(CLK_DIV - 1));
    assign slot_last = bit_end && (idx_q == IDX_W'(SLOT_W - 1));
    assign clk_phase = (div_q < DIV_W'(HALF));
    assign bit_idx   = idx_q;

    // Advance the cycle divider and the bit index within a slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            idx_q <= '0;
        end else if (bit_end) begin
            div_q <= '0;
            idx_q <= (idx_q == IDX_W'(SLOT_W - 1)) ? '0 : idx_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/enc_tx_slot_fmt.sv
// Slot formatter: builds the padded slot word for one payload.
// The word's MSB is sent first: LEAD_W ones, a 0 start bit, the payload
// MSB first, a 1 delimiter, and then ones up to SLOT_W bits.
// Assumes LEAD_W + PAY_W + 2 <= SLOT_W.
module enc_tx_slot_fmt #(
    parameter int PAY_W  = 16,
    parameter int SLOT_W = 32,
    parameter int LEAD_W = 7
) (
    input  logic [PAY_W-1:0]  payload,
    output logic [SLOT_W-1:0] slot_word
);
    localparam int START_POS = LEAD_W;
    localparam int DELIM_POS = LEAD_W + PAY_W + 1;

    // Place each transmitted bit position b at word bit SLOT_W-1-b.
    for (genvar b = 0; b < SLOT_W; b++) begin : g_bit
        if (b == START_POS) begin : g_start
            assign slot_word[SLOT_W-1-b] = 1'b0;
        end else if (b > START_POS && b < DELIM_POS) begin : g_pay
            assign slot_word[SLOT_W-1-b] = payload[PAY_W-1-(b-START_POS-1)];
        end else begin : g_pad
            assign slot_word[SLOT_W-1-b] = 1'b1;
        end
    end

endmodule

// File: rtl/enc_tx_seq.sv
// Frame sequencer: captures the host inputs on an accepted start, walks the
// command frame and the memory frames in turn, times the idle gap before
// each memory frame and raises done for one cycle at the end. Starts are
// ignored unless the sequencer is idle.
module enc_tx_seq
    import enc_tx_pkg::*;
#(
    parameter int PAY_W   = 16,
    parameter int MAX_MDF = 4,
    parameter int GAP_W   = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [PAY_W-1:0]                  cdf_payload,
    input  logic [$clog2(MAX_MDF+1)-1:0]      mdf_count,
    input  logic [MAX_MDF*PAY_W-1:0]          mdf_payload,
    input  logic [GAP_W-1:0]                  gap_cycles,
    input  logic                              slot_last,
    output tx_state_t                         state,
    output logic [PAY_W-1:0]                  cur_payload,
    output logic                              done
);
    localparam int SEL_W = $clog2(MAX_MDF + 1);
    localparam int NFR   = MAX_MDF + 1;

    tx_state_t        state_q;
    logic [PAY_W-1:0] frame_q [NFR];
    logic [SEL_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] gap_cnt_q;
    logic [SEL_W-1:0] cnt_clamped;
    logic             accept;

    assign accept      = start && (state_q == ST_IDLE);
    assign cnt_clamped = (mdf_count > SEL_W'(MAX_MDF)) ? SEL_W'(MAX_MDF) : mdf_count;
    assign state       = state_q;
    assign cur_payload = frame_q[sel_q];

    // Capture the command payload into slot 0 of the frame store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q[0] <= '0;
        end else if (accept) begin
            frame_q[0] <= cdf_payload;
        end
    end

    // Capture each memory payload into its own entry of the frame store.
    for (genvar k = 0; k < MAX_MDF; k++) begin : g_mdf
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_q[k+1] <= '0;
            end else if (accept) begin
                frame_q[k+1] <= mdf_payload[k*PAY_W +: PAY_W];
            end
        end
    end

    // Capture the frame count and the gap length for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            gap_q <= '0;
        end else if (accept) begin
            cnt_q <= cnt_clamped;
            gap_q <= gap_cycles;
        end
    end

    // Move between idle, slot and gap, and track the frame being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sel_q     <= '0;
            gap_cnt_q <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_SLOT;
                        sel_q   <= '0;
                    end
                end
                ST_SLOT: begin
                    if (slot_last) begin
                        if (sel_q < cnt_q) begin
                            sel_q <= sel_q + 1'b1;
                            if (gap_q == '0) begin
                                state_q <= ST_SLOT;
                            end else begin
                                state_q   <= ST_GAP;
                                gap_cnt_q <= gap_q;
                            end
                        end else begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    gap_cnt_q <= gap_cnt_q - 1'b1;
                    if (gap_cnt_q == GAP_W'(1)) begin
                        state_q <= ST_SLOT;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/enc_cmd_tx.sv
// Encoder command frame transmitter, top level.
// Joins the sequencer, the bit timer and the slot formatter, and derives the
// line outputs: data selected from the slot word, an enable held for the
// whole transfer, and a bit clock that runs only during slots.
module enc_cmd_tx
    import enc_tx_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int PAY_W   = PAY_BITS_DEF,
    parameter int SLOT_W  = SLOT_BITS_DEF,
    parameter int LEAD_W  = LEAD_BITS_DEF,
    parameter int MAX_MDF = 4,
    parameter int GAP_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [PAY_W-1:0]             cdf_payload,
    input  logic [$clog2(MAX_MDF+1)-1:0] mdf_count,
    input  logic [MAX_MDF*PAY_W-1:0]     mdf_payload,
    input  logic [GAP_W-1:0]             gap_cycles,
    output logic                         ser_clk,
    output logic                         ser_data,
    output logic                         ser_oe,
    output logic                         busy,
    output logic                         done
);
    localparam int IDX_W = $clog2(SLOT_W);

    tx_state_t         tx_state;
    logic [PAY_W-1:0]  cur_payload;
    logic [SLOT_W-1:0] slot_word;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  word_pos;
    logic              slot_last;
    logic              clk_phase;
    logic              in_slot;

    enc_tx_seq #(
        .PAY_W   (PAY_W),
        .MAX_MDF (MAX_MDF),
        .GAP_W   (GAP_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cdf_payload (cdf_payload),
        .mdf_count   (mdf_count),
        .mdf_payload (mdf_payload),
        .gap_cycles  (gap_cycles),
        .slot_last   (slot_last),
        .state       (tx_state),
        .cur_payload (cur_payload),
        .done        (done)
    );

    assign in_slot = (tx_state == ST_SLOT);

    enc_tx_bit_timer #(
        .CLK_DIV (CLK_DIV),
        .SLOT_W  (SLOT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (in_slot),
        .bit_idx   (bit_idx),
        .slot_last (slot_last),
        .clk_phase (clk_phase)
    );

    enc_tx_slot_fmt #(
        .PAY_W  (PAY_W),
        .SLOT_W (SLOT_W),
        .LEAD_W (LEAD_W)
    ) u_fmt (
        .payload   (cur_payload),
        .slot_word (slot_word)
    );

    // Select the current bit, send ones outside slots, and gate the bit clock.
    always_comb begin
        word_pos = IDX_W'(SLOT_W - 1) - bit_idx;
        ser_data = in_slot ? slot_word[word_pos] : 1'b1;
        ser_clk  = in_slot && clk_phase;
        ser_oe   = (tx_state != ST_IDLE);
        busy     = (tx_state != ST_IDLE);
    end

endmodule

// File: rtl/enc_cmd_tx_chk.sv
// Protocol checker for the encoder command frame transmitter. It is bound to
// every instance of the top module and watches the line outputs and the gap state.
module enc_cmd_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_oe,
    input logic in_gap
);

    // R1: when the line is released it stays high with the clock quiet.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> (ser_data && !ser_clk));

    // R4: the gap drives idle ones with the enable on and the clock stopped.
    p_gap_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap |-> (ser_data && !ser_clk && ser_oe));

    // R8: a start seen while idle begins a transfer in the next cycle.
    p_start_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9: done lasts a single cycle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done comes only in the first idle cycle after a busy one.
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

bind enc_cmd_tx enc_cmd_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_oe   (ser_oe),
    .in_gap   (tx_state == enc_tx_pkg::ST_GAP)
);

// File: tb/enc_cmd_tx_tb.sv
// Bench: a behavioural queue model predicts every output cycle and is
// compared on each negative edge. Directed transfers also check total length.
module enc_cmd_tx_tb;
    localparam int CLK_DIV = 4;
    localparam int PAY_W   = 16;
    localparam int MAX_MDF = 4;
    localparam int GAP_W   = 16;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic [PAY_W-1:0]         cdf_payload = '0;
    logic [2:0]               mdf_count = '0;
    logic [MAX_MDF*PAY_W-1:0] mdf_payload = '0;
    logic [GAP_W-1:0]         gap_cycles = '0;
    logic ser_clk, ser_data, ser_oe, busy, done;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic c;
        logic d;
        logic oe;
        logic dn;
        int   tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    enc_cmd_tx #(
        .CLK_DIV (CLK_DIV),
        .MAX_MDF (MAX_MDF),
        .GAP_W   (GAP_W)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cdf_payload (cdf_payload),
        .mdf_count   (mdf_count),
        .mdf_payload (mdf_payload),
        .gap_cycles  (gap_cycles),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .ser_oe      (ser_oe),
        .busy        (busy),
        .done        (done)
    );

    // Slot bits: 7 ones, 0 start, payload MSB first, 1 delimiter, ones (R2, R3).
    function automatic void push_slot(input logic [PAY_W-1:0] p);
        for (int b = 0; b < 32; b++) begin
            logic v;
            int   t;
            if (b == 7) begin v = 1'b0; t = 2; end
            else if (b >= 8 && b <= 23) begin v = p[23-b]; t = 2; end
            else if (b == 24) begin v = 1'b1; t = 2; end
            else begin v = 1'b1; t = 3; end
            for (int d = 0; d < CLK_DIV; d++) begin
                exp_t e;
                e.c = (d < CLK_DIV/2); e.d = v; e.oe = 1'b1; e.dn = 1'b0; e.tag = t;
                q.push_back(e);
            end
        end
    endfunction

    function automatic void push_xfer();
        int n;
        n = (mdf_count > 3'd4) ? 4 : int'(mdf_count);
        push_slot(cdf_payload);
        for (int k = 0; k < n; k++) begin
            for (int g = 0; g < int'(gap_cycles); g++) begin
                exp_t e;
                e.c = 1'b0; e.d = 1'b1; e.oe = 1'b1; e.dn = 1'b0; e.tag = 4;
                q.push_back(e);
            end
            push_slot(mdf_payload[k*PAY_W +: PAY_W]);
        end
        begin
            exp_t e;
            e.c = 1'b0; e.d = 1'b1; e.oe = 1'b0; e.dn = 1'b1; e.tag = 9;
            q.push_back(e);
        end
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model; R1 during reset and idle.
    always @(negedge clk) begin
        exp_t e;
        if (!rst_n) begin
            q.delete();
            e.c = 1'b0; e.d = 1'b1; e.oe = 1'b0; e.dn = 1'b0; e.tag = 1;
        end else if (q.size() > 0) begin
            e = q.pop_front();
        end else begin
            e.c = 1'b0; e.d = 1'b1; e.oe = 1'b0; e.dn = 1'b0; e.tag = 1;
        end
        chk($sformatf("R%0d ser_data", e.tag), 32'(ser_data), 32'(e.d));
        chk("R7 ser_clk", 32'(ser_clk), 32'(e.c));
        chk("R6 ser_oe", 32'(ser_oe), 32'(e.oe));
        chk("R6 busy", 32'(busy), 32'(e.oe));
        chk($sformatf("R%0d done", e.dn ? 9 : e.tag), 32'(done), 32'(e.dn));
        if (rst_n && start && !e.oe) push_xfer();
    end

    // Run one transfer and check its busy length; optionally restart mid-way (R8).
    task automatic run_xfer(input logic [15:0] cdf, input logic [2:0] cnt,
                            input logic [63:0] mdfs, input logic [15:0] gap,
                            input int nf, input string req, input bit mid);
        int count = 0;
        int exp_len;
        @(posedge clk); #1;
        cdf_payload = cdf; mdf_count = cnt; mdf_payload = mdfs; gap_cycles = gap;
        start = 1'b1;
        forever begin
            @(posedge clk); #1;
            if (busy) count++;
            if (mid && count == 40) begin
                start = 1'b1;
                cdf_payload = ~cdf;
                mdf_count = 3'd0;
                gap_cycles = 16'd1;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        exp_len = nf*32*CLK_DIV + (nf-1)*int'(gap);
        chk({req, " busy length"}, 32'(count), 32'(exp_len));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset oe", 32'(ser_oe), 32'd0);
        chk("R1 reset data", 32'(ser_data), 32'd1);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 idle busy", 32'(busy), 32'd0);
        // R2 R3: command frame alone, mixed and extreme payloads.
        run_xfer(16'hA5C3, 3'd0, 64'h0, 16'd9, 1, "R2", 1'b0);
        run_xfer(16'h0000, 3'd0, 64'h0, 16'd0, 1, "R3", 1'b0);
        run_xfer(16'hFFFF, 3'd0, 64'h0, 16'd0, 1, "R3", 1'b0);
        // R4: one memory frame after a gap.
        run_xfer(16'h1234, 3'd1, 64'h0000_0000_0000_8001, 16'd5, 2, "R4", 1'b0);
        // R5: four memory frames, distinct payloads in order.
        run_xfer(16'h0F0F, 3'd4, 64'hDEAD_BEEF_5A5A_3C3C, 16'd3, 5, "R5", 1'b0);
        // R5: a count above four is clamped.
        run_xfer(16'h7001, 3'd6, 64'h1111_2222_4444_8888, 16'd2, 5, "R5 clamp", 1'b0);
        // R10: zero gap gives back-to-back slots.
        run_xfer(16'hC001, 3'd2, 64'h0000_0000_00FF_FF00, 16'd0, 3, "R10", 1'b0);
        // R8: start and changed inputs during a transfer are ignored.
        run_xfer(16'h9A3E, 3'd1, 64'h0000_0000_0000_6006, 16'd7, 2, "R8", 1'b1);
        repeat (4) @(posedge clk);
        #1;
        chk("R1 idle after run", 32'(ser_oe), 32'd0);
        chk("R9 done low after run", 32'(done), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule